// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory. It watches an already-synchronized clock line and data line and recognises START, repeated START and STOP conditions. Each transfer opens with a select byte carrying a fixed device code, three bits that must match the chip-enable pins, and a read/write flag. Write transfers follow the select byte with a two-byte word address and then data. Read transfers return bytes from an internal address counter for as long as the master keeps acknowledging. The data line is driven only as an open-drain pull-down enable.

Written bytes go into a page buffer and reach the byte array only on STOP. The page is 32 bytes and the write pointer wraps inside it. A write-lock input lets select and address bytes through but refuses data bytes. The array depth is set by `ADDR_W`: the default of 10 gives 1 KiB, and 13 gives the full 8 KiB. The three chip-enable pins let up to eight such slaves share one bus.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A select byte is accepted only when bits [7:4] equal 4'b1010 and bits [3:1] equal chip_en_i[2:0]. Bit 0 is the direction (1 = read, 0 = write). A byte that does not match gets no acknowledge, and every later byte is ignored until the next START.
- R2: Bytes are received most significant bit first. After each accepted received byte the block acknowledges by asserting sda_oe_o (line pulled low) for the whole ninth clock pulse.
- R3: The word address is sent as two bytes, high byte first. Only the low ADDR_W bits of the 16 are used and higher bits are ignored.
- R4: A byte write stores its data byte at the word address, and a later read returns it.
- R5: In a page write the low 5 address bits step after each data byte and wrap inside the 32-byte page, so data bytes past the 32nd overwrite the earliest positions.
- R6: Written bytes reach the array only on STOP. A repeated START before STOP discards them.
- R7: While wr_lock_i is 1 the select and address bytes are acknowledged, but data bytes are not acknowledged and the array does not change.
- R8: A random read (select/write, word address, repeated START, select/read) returns the byte at that address.
- R9: A current address read returns the byte at the address following the last byte read.
- R10: A sequential read returns consecutive bytes while the master acknowledges, wrapping from the top address to 0. A master non-acknowledge makes the block release SDA.
- R11: While rst_ni is 0 the block never asserts sda_oe_o and ignores the bus, so the array does not change.
- R12: sda_oe_o rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (resolved line) |
| chip_en_i | input | 3 | Chip-enable bits compared with select bits [3:1] |
| wr_lock_i | input | 1 | Refuses data bytes of writes when 1 |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
Every response is registered once after the SCL fall is seen. This covers an acknowledge, the first or next read bit, and a release. Each response is therefore valid on the clock edge right after SCL goes low. The bench waits two clocks after each SCL edge before it moves SDA or raises SCL, and it samples the line in the middle of the SCL high time. Array writes land one clock after the STOP edge, so read-back checks always begin with a fresh START after a completed STOP.

// File: rtl/i2c_ee_pkg.sv
`timescale 1ns/1ps
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } ee_state_e;
endpackage

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges with clock held high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_page_buf.sv
`timescale 1ns/1ps
module ee_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       wr_i,
  input  logic [PAGE_W-1:0]          idx_i,
  input  logic [7:0]                 data_i,
  output logic [(1<<PAGE_W)-1:0][7:0] data_o,
  output logic [(1<<PAGE_W)-1:0]     valid_o
);
  localparam int PAGE = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_ent
    logic [7:0] ent_q;
    logic       vld_q;

    always_ff @(posedge clk_i) begin
      if (wr_i && idx_i == PAGE_W'(g)) ent_q <= data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          vld_q <= 1'b0;
      else if (clear_i)                     vld_q <= 1'b0;
      else if (wr_i && idx_i == PAGE_W'(g)) vld_q <= 1'b1;
    end

    assign data_o[g]  = ent_q;
    assign valid_o[g] = vld_q;
  end
endmodule

// File: rtl/ee_array.sv
`timescale 1ns/1ps
module ee_array #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                        clk_i,
  input  logic                        commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]    page_i,
  input  logic [(1<<PAGE_W)-1:0][7:0] pdata_i,
  input  logic [(1<<PAGE_W)-1:0]      pvalid_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [7:0]                  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pvalid_i[i]) mem_q[{page_i, PAGE_W'(i)}] <= pdata_i[i];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave #(
  parameter int         ADDR_W   = 10,
  parameter int         PAGE_W   = 5,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_en_i,
  input  logic       wr_lock_i,
  output logic       sda_oe_o
);
  import i2c_ee_pkg::*;

  localparam int PAGE = 1 << PAGE_W;
  localparam int HI_W = ADDR_W - 8;

  logic scl_rise, scl_fall, bus_start, bus_stop;

  ee_state_e        state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       shreg_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]  ahi_q;
  logic             mack_q, oe_q;

  logic [PAGE-1:0][7:0] pdata;
  logic [PAGE-1:0]      pvalid;
  logic [7:0]           rdata;
  logic dev_ok, byte_end, buf_wr, buf_clr, commit;

  i2c_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  assign dev_ok   = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == chip_en_i);
  assign byte_end = scl_fall && cnt_q == 4'd8;
  assign buf_wr   = byte_end && state_q == ST_WDATA && !wr_lock_i;
  assign buf_clr  = bus_start || bus_stop ||
                    (byte_end && state_q == ST_ALO) ||
                    (byte_end && state_q == ST_WDATA && wr_lock_i);
  assign commit   = bus_stop && (|pvalid);

  ee_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (buf_clr),
    .wr_i    (buf_wr),
    .idx_i   (addr_q[PAGE_W-1:0]),
    .data_i  (shreg_q),
    .data_o  (pdata),
    .valid_o (pvalid)
  );

  ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk_i    (clk_i),
    .commit_i (commit),
    .page_i   (addr_q[ADDR_W-1:PAGE_W]),
    .pdata_i  (pdata),
    .pvalid_i (pvalid),
    .raddr_i  (addr_q),
    .rdata_o  (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      ahi_q   <= '0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (bus_start) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (bus_stop) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      // bits counted on rise: 0..7 data, 8 ack, 9 ack done
      if (scl_rise) begin
        if (cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_i};
        else              mack_q  <= ~sda_i;
        cnt_q <= cnt_q + 4'd1;
      end
      if (scl_fall) begin
        if (cnt_q == 4'd8) begin
          unique case (state_q)
            ST_DEV: begin
              if (dev_ok) begin
                oe_q    <= 1'b1;
                mack_q  <= 1'b1;
                state_q <= shreg_q[0] ? ST_RDATA : ST_AHI;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_AHI: begin
              oe_q    <= 1'b1;
              ahi_q   <= shreg_q[HI_W-1:0];
              state_q <= ST_ALO;
            end
            ST_ALO: begin
              oe_q    <= 1'b1;
              addr_q  <= {ahi_q, shreg_q};
              state_q <= ST_WDATA;
            end
            ST_WDATA: begin
              if (wr_lock_i) begin
                state_q <= ST_IDLE;
              end else begin
                oe_q   <= 1'b1;
                addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              end
            end
            ST_RDATA: oe_q <= 1'b0;
            default:  state_q <= ST_IDLE;
          endcase
        end else if (cnt_q == 4'd9) begin
          cnt_q <= '0;
          if (state_q == ST_RDATA && mack_q) begin
            tx_q   <= {rdata[6:0], 1'b0};
            oe_q   <= ~rdata[7];
            addr_q <= addr_q + 1'b1;
          end else begin
            oe_q <= 1'b0;
            if (state_q == ST_RDATA) state_q <= ST_IDLE;
          end
        end else if (state_q == ST_RDATA && cnt_q != 4'd0) begin
          oe_q <= ~tx_q[7];
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_chk #(
  parameter int         ADDR_W   = 10,
  parameter int         PAGE_W   = 5,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    scl_i,
  input logic                    scl_fall,
  input logic                    wr_lock_i,
  input logic [2:0]              chip_en_i,
  input logic                    sda_oe_o,
  input i2c_ee_pkg::ee_state_e   state_q,
  input logic [3:0]              cnt_q,
  input logic [7:0]              shreg_q,
  input logic [ADDR_W-1:0]       addr_q
);
  import i2c_ee_pkg::*;

  always @(posedge clk_i) begin
    if (!rst_ni) a_r11_quiet_in_reset: assert (!sda_oe_o);
  end

  a_r12_rise_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  a_r1_no_ack_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEV && scl_fall && cnt_q == 4'd8 &&
     ({shreg_q[7:4], shreg_q[3:1]} != {DEV_CODE, chip_en_i})) |=> !sda_oe_o);

  a_r7_lock_refuses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDATA && scl_fall && cnt_q == 4'd8 && wr_lock_i) |=> !sda_oe_o);

  a_r5_page_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDATA && $past(state_q) == ST_WDATA) |->
      addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

  a_r2_bit_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd9);
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .scl_fall  (scl_fall),
  .wr_lock_i (wr_lock_i),
  .chip_en_i (chip_en_i),
  .sda_oe_o  (sda_oe_o),
  .state_q   (state_q),
  .cnt_q     (cnt_q),
  .shreg_q   (shreg_q),
  .addr_q    (addr_q)
);

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] chip_en = 3'd0;
  logic       wr_lock = 1'b0;
  logic       sda_oe;
  logic       sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  int r12_viol = 0;

  logic [7:0] model [DEPTH];
  logic [7:0] rbuf  [64];

  always #10 clk_i = ~clk_i;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.ADDR_W(ADDR_W)) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .chip_en_i (chip_en),
    .wr_lock_i (wr_lock),
    .sda_oe_o  (sda_oe)
  );

  // R12 monitor: output updates at posedge, scl only moves at negedge
  logic oe_prev = 1'b0;
  always @(posedge clk_i) begin
    #5;
    if (rst_ni && sda_oe && !oe_prev && scl) r12_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(2); scl = 1'b1; wt(2);
    sda_m = 1'b0; wt(2); scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(2); scl = 1'b1; wt(2);
    sda_m = 1'b1; wt(4);
  endtask

  task automatic bit_tx(input logic b);
    sda_m = b; wt(2); scl = 1'b1; wt(4); scl = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bit_tx(b[i]);
    sda_m = 1'b1; wt(2); scl = 1'b1; wt(2);
    ack = !sda_bus;
    wt(2); scl = 1'b0; wt(2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(2); scl = 1'b1; wt(2);
      d[i] = sda_bus;
      wt(2); scl = 1'b0;
    end
    wt(2);
    bit_tx(!mack);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic [2:0] ce, input logic rw);
    return {4'b1010, ce, rw};
  endfunction

  // write n bytes from seed; ack_all reports whether all bytes were acknowledged
  task automatic wr_page(input logic [7:0] ahi, input logic [7:0] alo, input int n,
                         input int seed, output bit ack_all);
    bit a;
    int eff;
    eff = {ahi, alo} & (DEPTH - 1);
    ack_all = 1'b1;
    bus_start();
    send_byte(sel(chip_en, 1'b0), a); ack_all &= a;
    send_byte(ahi, a); ack_all &= a;
    send_byte(alo, a); ack_all &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(8'((seed + k * 7) & 8'hFF), a); ack_all &= a;
    end
    bus_stop();
    if (ack_all)
      for (int k = 0; k < n; k++)
        model[(eff & ~31) | ((eff + k) & 31)] = 8'((seed + k * 7) & 8'hFF);
  endtask

  task automatic rd_rand(input int addr, input int n);
    bit a;
    bus_start();
    send_byte(sel(chip_en, 1'b0), a);
    send_byte(8'(addr >> 8), a);
    send_byte(8'(addr & 8'hFF), a);
    bus_start();
    send_byte(sel(chip_en, 1'b1), a);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit a, all;
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

    wt(3);
    chk(sda_oe == 1'b0, "R11 reset state", int'(sda_oe), 0);
    wt(2);
    rst_ni = 1'b1;
    wt(4);

    // R1/R2: chip-enable sweep, ack only on exact match
    for (int p = 0; p < 8; p++) begin
      chip_en = 3'(p);
      for (int s = 0; s < 8; s++) begin
        bus_start();
        send_byte(sel(3'(s), 1'b0), a);
        bus_stop();
        chk(a == (p == s), "R1 R2 select ack", int'(a), int'(p == s));
      end
    end
    chip_en = 3'd5;
    // R1: wrong device code never acknowledged
    for (int c = 0; c < 16; c++) begin
      if (c == 10) continue;
      bus_start();
      send_byte({4'(c), 3'd5, 1'b0}, a);
      bus_stop();
      chk(!a, "R1 code mismatch", int'(a), 0);
    end
    // R1: after mismatch, a matching byte without START is ignored
    bus_start();
    send_byte(sel(3'd2, 1'b0), a);
    send_byte(sel(3'd5, 1'b0), a);
    bus_stop();
    chk(!a, "R1 idle until START", int'(a), 0);

    // R4/R8: byte write then random read
    wr_page(8'h01, 8'h23, 1, 8'h3C, all);
    chk(all, "R4 byte write acks", int'(all), 1);
    rd_rand(12'h123, 1);
    chk(rbuf[0] == model[12'h123], "R4 R8 read back", rbuf[0], model[12'h123]);

    // R3: upper address bits ignored
    wr_page(8'hF1, 8'h23, 1, 8'h77, all);
    rd_rand(12'h123, 1);
    chk(rbuf[0] == 8'h77, "R3 high bits ignored", rbuf[0], 8'h77);

    // R5: page write from offset 20, 32 bytes wrap within page 0x040
    wr_page(8'h00, 8'h54, 32, 8'h80, all);
    chk(all, "R5 page acks", int'(all), 1);
    rd_rand(12'h040, 32);
    for (int k = 0; k < 32; k++)
      chk(rbuf[k] == model[12'h040 + k], "R5 R10 page wrap", rbuf[k], model[12'h040 + k]);

    // R9: counter now points at 0x060
    wr_page(8'h00, 8'h60, 34, 8'h11, all);
    rd_rand(12'h03F, 1);
    bus_start();
    send_byte(sel(chip_en, 1'b1), a);
    recv_byte(1'b0, d);
    bus_stop();
    chk(d == model[12'h040], "R9 current address", d, model[12'h040]);
    // R5: 34 bytes, first two overwritten by the last two
    rd_rand(12'h060, 32);
    chk(rbuf[0] == 8'((8'h11 + 32 * 7) & 8'hFF), "R5 overrun byte0", rbuf[0], 8'((8'h11 + 32 * 7) & 8'hFF));
    chk(rbuf[1] == 8'((8'h11 + 33 * 7) & 8'hFF), "R5 overrun byte1", rbuf[1], 8'((8'h11 + 33 * 7) & 8'hFF));
    chk(rbuf[2] == 8'((8'h11 + 2 * 7) & 8'hFF), "R5 overrun byte2", rbuf[2], 8'((8'h11 + 2 * 7) & 8'hFF));
    bus_start();
    send_byte(sel(chip_en, 1'b1), a);
    recv_byte(1'b0, d);
    bus_stop();
    chk(d == model[12'h080], "R9 after sequential", d, model[12'h080]);

    // R6: data followed by repeated START is discarded
    bus_start();
    send_byte(sel(chip_en, 1'b0), a);
    send_byte(8'h01, a);
    send_byte(8'h23, a);
    send_byte(8'h99, a);
    bus_start();
    send_byte(sel(chip_en, 1'b0), a);
    send_byte(8'h01, a);
    send_byte(8'h23, a);
    bus_start();
    send_byte(sel(chip_en, 1'b1), a);
    recv_byte(1'b0, d);
    bus_stop();
    chk(d == 8'h77, "R6 no commit on restart", d, 8'h77);
    rd_rand(12'h123, 1);
    chk(rbuf[0] == 8'h77, "R6 still unchanged", rbuf[0], 8'h77);

    // R7: write lock
    wr_lock = 1'b1;
    bus_start();
    send_byte(sel(chip_en, 1'b0), a); chk(a, "R7 select acked", int'(a), 1);
    send_byte(8'h01, a);              chk(a, "R7 addr hi acked", int'(a), 1);
    send_byte(8'h23, a);              chk(a, "R7 addr lo acked", int'(a), 1);
    send_byte(8'h42, a);              chk(!a, "R7 data refused", int'(a), 0);
    bus_stop();
    wr_lock = 1'b0;
    rd_rand(12'h123, 1);
    chk(rbuf[0] == 8'h77, "R7 memory unchanged", rbuf[0], 8'h77);

    // R10: sequential read wraps from top to 0
    wr_page(8'h03, 8'hFE, 2, 8'hD0, all);
    wr_page(8'h00, 8'h00, 2, 8'h21, all);
    rd_rand(DEPTH - 2, 4);
    for (int k = 0; k < 4; k++)
      chk(rbuf[k] == model[(DEPTH - 2 + k) % DEPTH], "R10 wrap read",
          rbuf[k], model[(DEPTH - 2 + k) % DEPTH]);
    // R10: release after master non-acknowledge
    bus_start();
    send_byte(sel(chip_en, 1'b1), a);
    recv_byte(1'b0, d);
    wt(2);
    chk(sda_oe == 1'b0, "R10 release after nack", int'(sda_oe), 0);
    bus_stop();

    // R11: bus ignored during reset
    wr_page(8'h00, 8'h55, 1, 8'hA5, all);
    rst_ni = 1'b0;
    wt(2);
    bus_start();
    send_byte(sel(chip_en, 1'b0), a);
    chk(!a, "R11 no ack in reset", int'(a), 0);
    send_byte(8'h00, a);
    send_byte(8'h55, a);
    send_byte(8'h5A, a);
    bus_stop();
    rst_ni = 1'b1;
    wt(4);
    rd_rand(12'h055, 1);
    chk(rbuf[0] == 8'hA5, "R11 memory kept", rbuf[0], 8'hA5);

    chk(r12_viol == 0, "R12 drive only with scl low", r12_viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule